// File: doc/BRIEF.md
# Byte/Word Load-Store Unit

This unit connects a 32-bit register datapath to a byte-addressable synchronous data memory. For each request it adds a sign-extended 16-bit displacement to a base register value to form an effective address, then issues either a full-word or a single-byte access. Memory words sit four addresses apart. Within a word the bytes are little-endian: effective-address bits [1:0] choose lane 0 to 3, and lane k occupies data bits [8k+7:8k].

Byte stores replicate the low source byte onto every lane and raise exactly one byte-enable, so the rest of the memory word keeps its contents. Byte loads pick out the addressed lane and sign-extend it to 32 bits. A word access whose effective address is not a multiple of four is refused. The error output rises in the same cycle as the request and the memory is never enabled for it. Accepted loads return their data one cycle later, together with a valid strobe.

Top module: `lsu_byteword`

## Requirements
- R1: The effective address is base plus the 16-bit displacement sign-extended to 32 bits, for any displacement from -32768 to +32767. The memory address is that sum with bits [1:0] forced to zero.
- R2: A word request (req_byte=0) whose effective address has nonzero bits [1:0] raises bus_err in the same cycle. It keeps mem_en low, so memory contents are unchanged, and no ld_valid follows.
- R3: A byte request (req_byte=1) never raises bus_err, for any address.
- R4: An aligned word store drives mem_en=1, mem_we=1, mem_be=4'b1111 and mem_wdata equal to the source word.
- R5: A byte store drives mem_be with only bit k set, where k is the effective address [1:0]. The lane at bits [8k+7:8k] of mem_wdata carries the source bits [7:0]. The other three bytes of the memory word keep their values.
- R6: An accepted word load drives mem_we=0 and mem_be=0. One cycle later it gives ld_valid=1 and ld_data equal to the stored word.
- R7: A byte load returns the addressed lane in ld_data[7:0], with ld_data[31:8] filled with copies of that byte's bit 7.
- R8: After reset, and in any cycle with req_valid=0, mem_en and bus_err are 0. ld_valid is 1 only in the cycle after an accepted load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| wdata | input | 32 | Store source register |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 4 | Byte enables, bit k = lane k |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the read |
| ld_valid | output | 1 | Load data valid |
| ld_data | output | 32 | Load result |
| bus_err | output | 1 | Misaligned word access flag |

## Verification
The assertions assume the memory answers an enabled read on the next clock edge. They also assume the request inputs, which feed the error and enable paths combinationally, are stable when the clock edge samples them. The bench drives every request on the falling edge and holds req_valid low whenever it is not issuing one. Its memory model returns read data exactly one cycle after mem_en with mem_we low. Random effective addresses are kept inside a small modelled memory: the bench chooses the target address and the displacement, then derives the base from them, so the full displacement range stays in use.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic {SZ_WORD = 1'b0, SZ_BYTE = 1'b1} lsu_size_e;

  function automatic logic [31:0] widen_disp(input logic [15:0] d);
    return {{16{d[15]}}, d};
  endfunction

  function automatic logic [31:0] widen_byte(input logic [7:0] b);
    return {{24{b[7]}}, b};
  endfunction
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] ea
);
  localparam int EXT_W = ADDR_W - OFF_W;
  logic [ADDR_W-1:0] disp_ext;

  assign disp_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
  assign ea       = base + disp_ext;
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
  parameter int LANE_W = 2
) (
  input  logic              req_valid,
  input  lsu_pkg::lsu_size_e size,
  input  logic [LANE_W-1:0] ea_low,
  output logic              fault,
  output logic              accept
);
  logic misaligned;

  assign misaligned = (size == lsu_pkg::SZ_WORD) && (ea_low != '0);
  assign fault      = req_valid && misaligned;
  assign accept     = req_valid && !misaligned;

  always_comb begin
    if (req_valid && size == lsu_pkg::SZ_BYTE)
      a_r3_byte_no_fault: assert (!fault);
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer #(
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              is_byte,
  input  logic [LANE_W-1:0] lane,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] data
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be[g]          = is_byte ? (lane == LANE_W'(g)) : 1'b1;
    assign data[8*g +: 8] = is_byte ? wdata[7:0] : wdata[8*g +: 8];
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              is_byte,
  input  logic [LANE_W-1:0] lane,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] data
);
  logic [7:0] lane_bytes [LANES];
  logic [7:0] picked;

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign lane_bytes[g] = rdata[8*g +: 8];
  end

  assign picked = lane_bytes[lane];
  assign data   = is_byte ? {{(DATA_W-8){picked[7]}}, picked} : rdata;
endmodule

// File: rtl/lsu_byteword.sv
module lsu_byteword #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_byte,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] wdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [LANES-1:0]  mem_be,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data,
  output logic              bus_err
);
  import lsu_pkg::*;

  lsu_size_e         size;
  logic [ADDR_W-1:0] ea;
  logic [LANE_W-1:0] lane;
  logic              accept;
  logic              fault;
  logic [LANES-1:0]  be_steer;
  logic              ld_accept;
  logic              ld_pend_q;
  logic              ld_byte_q;
  logic [LANE_W-1:0] ld_lane_q;

  assign size = req_byte ? SZ_BYTE : SZ_WORD;
  assign lane = ea[LANE_W-1:0];

  lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_agen (
    .base(base), .offset(offset), .ea(ea)
  );

  lsu_align_chk #(.LANE_W(LANE_W)) u_align (
    .req_valid(req_valid), .size(size), .ea_low(lane),
    .fault(fault), .accept(accept)
  );

  lsu_store_steer #(.DATA_W(DATA_W)) u_steer (
    .is_byte(req_byte), .lane(lane), .wdata(wdata),
    .be(be_steer), .data(mem_wdata)
  );

  assign mem_en    = accept;
  assign mem_we    = accept && req_write;
  assign mem_be    = mem_we ? be_steer : '0;
  assign mem_addr  = {ea[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
  assign bus_err   = fault;
  assign ld_accept = accept && !req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_pend_q <= 1'b0;
      ld_byte_q <= 1'b0;
      ld_lane_q <= '0;
    end else begin
      ld_pend_q <= ld_accept;
      if (ld_accept) begin
        ld_byte_q <= req_byte;
        ld_lane_q <= lane;
      end
    end
  end

  lsu_load_extract #(.DATA_W(DATA_W)) u_extract (
    .is_byte(ld_byte_q), .lane(ld_lane_q), .rdata(mem_rdata), .data(ld_data)
  );

  assign ld_valid = ld_pend_q;

  a_r1_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_addr[LANE_W-1:0] == '0));
  a_r2_fault_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> !mem_en);
  a_r2_fault_no_return: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> !ld_valid);
  a_r4_word_store_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !req_byte) |-> (mem_be == '1));
  a_r5_byte_store_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && req_byte) |-> ($countones(mem_be) == 1));
  a_r6_load_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> ld_valid);
  a_r7_byte_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_byte_q) |-> (ld_data[DATA_W-1:7] == '0 || ld_data[DATA_W-1:7] == '1));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!mem_en && !bus_err));
  a_r8_valid_only_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(mem_en && !mem_we));
endmodule

// File: tb/lsu_byteword_bench.sv
module lsu_byteword_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
  logic [31:0] base = '0, wdata = '0;
  logic [15:0] offset = '0;
  logic        mem_en, mem_we, ld_valid, bus_err;
  logic [3:0]  mem_be;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic [31:0] mem_rdata = '0;
  logic [31:0] ram [64];
  logic [31:0] shadow [64];
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  lsu_byteword u_lsu_byteword (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_byte(req_byte), .base(base), .offset(offset), .wdata(wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ld_valid(ld_valid),
    .ld_data(ld_data), .bus_err(bus_err)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int k = 0; k < 4; k++)
          if (mem_be[k]) ram[mem_addr[7:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
      end else begin
        mem_rdata <= ram[mem_addr[7:2]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] b_sext(input logic [7:0] b);
    return (b >= 8'd128) ? (32'hFFFF_FF00 + 32'(b)) : 32'(b);
  endfunction

  task automatic access(input bit wr, input bit isb, input logic [7:0] ea,
                        input logic [15:0] off, input logic [31:0] wd);
    logic [31:0] full_ea, exp_ld;
    bit flt;
    int idx, ln;
    full_ea = {24'h0, ea};
    idx = int'(ea[7:2]);
    ln  = int'(ea[1:0]);
    flt = !isb && (ln != 0);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_byte = isb;
    offset = off; base = full_ea - 32'($signed(off)); wdata = wd;
    #1;
    chk(bus_err == flt, isb ? "R3 byte never faults" : "R2 misaligned word flag", 32'(bus_err), 32'(flt));
    chk(mem_en == !flt, "R2 enable suppressed on fault", 32'(mem_en), 32'(!flt));
    if (!flt) begin
      chk(mem_addr == (full_ea & ~32'd3), "R1 effective address", mem_addr, full_ea & ~32'd3);
      if (wr && !isb) begin
        chk(mem_be == 4'hF && mem_we, "R4 word store enables", 32'(mem_be), 32'hF);
        chk(mem_wdata == wd, "R4 word store data", mem_wdata, wd);
        shadow[idx] = wd;
      end else if (wr) begin
        chk(mem_be == (4'b1 << ln), "R5 byte store lane enable", 32'(mem_be), 32'(4'b1 << ln));
        chk(mem_wdata[8*ln +: 8] == wd[7:0], "R5 byte store lane data", 32'(mem_wdata[8*ln +: 8]), 32'(wd[7:0]));
        shadow[idx][8*ln +: 8] = wd[7:0];
      end else begin
        chk(!mem_we && mem_be == 4'h0, "R6 load has no write enables", 32'(mem_be), 32'h0);
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(ld_valid == (!wr && !flt), "R8 load valid timing", 32'(ld_valid), 32'(!wr && !flt));
    if (!wr && !flt) begin
      exp_ld = isb ? b_sext(shadow[idx][8*ln +: 8]) : shadow[idx];
      chk(ld_data == exp_ld, isb ? "R7 byte load sign extend" : "R6 word load data", ld_data, exp_ld);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] sd;
    sd = $urandom(32'd4242);
    for (int i = 0; i < 64; i++) begin
      ram[i] = 32'(i) * 32'h9E37_79B9 + 32'h1357_0000;
      shadow[i] = ram[i];
    end
    repeat (3) @(negedge clk);
    chk(!mem_en && !bus_err && !ld_valid, "R8 reset state", {29'h0, mem_en, bus_err, ld_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!mem_en && !bus_err && !ld_valid, "R8 idle after reset", {29'h0, mem_en, bus_err, ld_valid}, 32'h0);
    // R1 displacement extremes
    access(1'b0, 1'b0, 8'd40, 16'h8000, '0);
    access(1'b0, 1'b0, 8'd44, 16'h7FFF, '0);
    access(1'b1, 1'b0, 8'd16, 16'hFFFC, 32'hCAFE_F00D);
    access(1'b0, 1'b0, 8'd16, 16'h0004, '0);
    // R5 each lane then read back whole word
    for (int k = 0; k < 4; k++) access(1'b1, 1'b1, 8'd20 + 8'(k), 16'(k * 3), 32'h1234_5600 + 32'(8'h7F + k));
    access(1'b0, 1'b0, 8'd20, 16'h0010, '0);
    // R7 negative and positive bytes
    access(1'b0, 1'b1, 8'd21, 16'h0001, '0);
    access(1'b0, 1'b1, 8'd20, 16'hFFFF, '0);
    // R2 misaligned store leaves memory untouched
    access(1'b1, 1'b0, 8'd18, 16'h0002, 32'hDEAD_BEEF);
    access(1'b0, 1'b0, 8'd16, 16'h0000, '0);
    access(1'b0, 1'b0, 8'd51, 16'h0000, '0);
    for (int i = 0; i < 400; i++)
      access(1'($urandom), 1'($urandom), 8'($urandom), 16'($urandom), $urandom);
    @(negedge clk); #1;
    chk(!mem_en && !bus_err && !ld_valid, "R8 idle at end", {29'h0, mem_en, bus_err, ld_valid}, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule